// File: doc/BRIEF.md
# Pointer-Indexed Control Register Bank

This block is the host-facing register file of a small data-acquisition card. It sits on an 8-bit bus with a 3-bit offset. Three control registers share a single write offset, and two status views share a single read offset. A two-bit pointer, held in a select register, decides which register is reached. Writes to the select register either move the pointer or load a four-bit analog range code. Bit 7 of the written byte chooses which of the two happens, so one action never disturbs the other.

The pointer is a four-state machine: PTR_CTRL1 (code 00), PTR_CONV (01), PTR_SCAN (10) and PTR_ID (11). There is one transition type, "point". It fires on a select write with bit 7 set and moves to the state coded in bits 5..4 of the data. Every other cycle takes the "hold" transition and keeps the state. Reset enters PTR_CTRL1.

The bank also holds the interrupt flag. The conversion path sets this flag, and any host write to the first control register clears it. While hardware conversions are enabled, the conversion-configuration register is locked. A write then only restarts conversions or turns them off. Read views expose the select register, the live status byte and either a mirror of the conversion configuration or the board identifier.

Top module: `dcr_regbank`

## Requirements
- R1: After reset, all register outputs, pulses and the interrupt flag are 0, and the pointer is PTR_CTRL1. Reads at offsets 2, 3 and 7 return 0 while the status inputs are 0.
- R2: A write to offset 3 with bit 7 = 0 loads bits 3..0 into the range code and leaves the pointer unchanged. With bit 7 = 1, it loads bits 5..4 into the pointer and leaves the range code unchanged. A read at offset 3 returns {2'b00, pointer, range}.
- R3: A write to offset 2 in PTR_CTRL1 loads the digital outputs from bits 7..4, the interrupt enable from bit 3 and the mux channel from bits 2..0.
- R4: A write to offset 2 in PTR_CTRL1 never touches the conversion configuration. A write in PTR_CONV while the enable bit (bit 0) is 0 loads the configuration with bit 6 forced to 0. Every PTR_CONV write raises trig_rearm for one cycle. If data bit 0 is 1, the write also raises conv_start for one cycle.
- R5: While configuration bit 0 is 1, a PTR_CONV write with data bit 0 = 1 leaves all configuration bits unchanged and pulses conv_start. A write with data bit 0 = 0 clears only bit 0.
- R6: A write to offset 2 in PTR_SCAN loads the first scan channel from bits 2..0 and the last scan channel from bits 5..3.
- R7: A write to offset 2 in PTR_ID changes no register.
- R8: irq_event sets the interrupt flag on the next edge. Any write to offset 2 in PTR_CTRL1 clears it. If both happen in the same cycle, the set wins.
- R9: irq_req is high exactly when the interrupt flag and the interrupt enable are both 1.
- R10: A read at offset 2 returns {conv_busy, din[2:0], interrupt flag, cur_chan}.
- R11: A read at offset 7 returns the conversion configuration in pointer states 00, 01 and 10. In PTR_ID it returns BOARD_ID in bits 1..0 and 0 in bits 7..2.
- R12: Reads at offsets 0, 1, 4, 5 and 6 return 0. Writes at offsets other than 2 and 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| conv_busy | input | 1 | Converter busy status |
| din | input | 3 | Digital input lines 3..1 |
| cur_chan | input | 3 | Channel currently being converted |
| irq_event | input | 1 | Interrupt condition from the conversion path |
| dout | output | 4 | Digital output lines |
| irq_en | output | 1 | Interrupt enable |
| mux_chan | output | 3 | Single-channel mux select |
| conv_cfg | output | 8 | Conversion configuration; bit 0 is the enable, bit 6 is always 0 |
| conv_start | output | 1 | One-cycle start pulse |
| trig_rearm | output | 1 | One-cycle trigger re-arm pulse |
| scan_first | output | 3 | First channel of the automatic scan |
| scan_last | output | 3 | Last channel of the automatic scan |
| range_code | output | 4 | Analog range code |
| irq_req | output | 1 | Interrupt request to the host |

## Verification
Two functions can land on the same clock edge: a host write to the first control register, which clears the interrupt flag, and an irq_event from the conversion path, which sets it. The bench drives irq_event high during the very cycle of such a write. It then reads offset 2 and expects the flag bit still set, with irq_req following the newly written enable. It also runs the lone clear and the lone set on their own, so that a wrong priority shows up against both neighbours.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
    localparam int unsigned ADDR_W = 3;
    localparam int unsigned DATA_W = 8;

    localparam logic [ADDR_W-1:0] OFF_CTRL  = 3'd2;
    localparam logic [ADDR_W-1:0] OFF_SEL   = 3'd3;
    localparam logic [ADDR_W-1:0] OFF_STAT2 = 3'd7;

    typedef enum logic [1:0] {
        PTR_CTRL1 = 2'b00,
        PTR_CONV  = 2'b01,
        PTR_SCAN  = 2'b10,
        PTR_ID    = 2'b11
    } ptr_e;

    localparam int unsigned CONV_EN_BIT   = 0;
    localparam int unsigned CONV_RSVD_BIT = 6;
    localparam logic [DATA_W-1:0] CONV_WMASK = ~(8'h01 << CONV_RSVD_BIT);
endpackage

// File: rtl/dcr_ptr_fsm.sv
module dcr_ptr_fsm
    import dcr_pkg::*;
#(
    parameter int unsigned RANGE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_wr,
    input  logic               ptr_we,
    input  logic [1:0]         ptr_val,
    input  logic [RANGE_W-1:0] range_val,
    output ptr_e               ptr_q,
    output logic [3:0]         sel_oh,
    output logic [RANGE_W-1:0] range_q
);
    ptr_e ptr_d;

    // next-state: "point" on select write with enable bit, else "hold"
    always_comb begin
        ptr_d = ptr_q;
        if (sel_wr && ptr_we) begin
            ptr_d = ptr_e'(ptr_val);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= PTR_CTRL1;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            range_q <= '0;
        end else if (sel_wr && !ptr_we) begin
            range_q <= range_val;
        end
    end

    // output decode: one-hot target per state
    always_comb begin
        sel_oh = 4'b0000;
        unique case (ptr_q)
            PTR_CTRL1: sel_oh = 4'b0001;
            PTR_CONV:  sel_oh = 4'b0010;
            PTR_SCAN:  sel_oh = 4'b0100;
            PTR_ID:    sel_oh = 4'b1000;
        endcase
    end
endmodule

// File: rtl/dcr_ctrl_regs.sv
module dcr_ctrl_regs
    import dcr_pkg::*;
#(
    parameter int unsigned CHAN_W = 3,
    parameter int unsigned DOUT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [3:0]        sel_oh,
    input  logic [DATA_W-1:0] wdata,
    output logic [DOUT_W-1:0] dout,
    output logic              irq_en,
    output logic [CHAN_W-1:0] mux_chan,
    output logic [DATA_W-1:0] conv_cfg,
    output logic              conv_start,
    output logic              trig_rearm,
    output logic [CHAN_W-1:0] scan_first,
    output logic [CHAN_W-1:0] scan_last,
    output logic              ctrl1_wr
);
    localparam int unsigned SCAN_HI = 2 * CHAN_W - 1;

    logic conv_wr, scan_wr;

    assign ctrl1_wr = ctrl_wr && sel_oh[0];
    assign conv_wr  = ctrl_wr && sel_oh[1];
    assign scan_wr  = ctrl_wr && sel_oh[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout     <= '0;
            irq_en   <= 1'b0;
            mux_chan <= '0;
        end else if (ctrl1_wr) begin
            {dout, irq_en, mux_chan} <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            conv_cfg   <= '0;
            conv_start <= 1'b0;
            trig_rearm <= 1'b0;
        end else begin
            conv_start <= conv_wr && wdata[CONV_EN_BIT];
            trig_rearm <= conv_wr;
            if (conv_wr) begin
                if (conv_cfg[CONV_EN_BIT]) begin
                    conv_cfg[CONV_EN_BIT] <= wdata[CONV_EN_BIT];
                end else begin
                    conv_cfg <= wdata & CONV_WMASK;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scan_first <= '0;
            scan_last  <= '0;
        end else if (scan_wr) begin
            {scan_last, scan_first} <= wdata[SCAN_HI:0];
        end
    end
endmodule

// File: rtl/dcr_irq.sv
module dcr_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_event,
    input  logic ctrl1_wr,
    input  logic irq_en,
    output logic irq_flag,
    output logic irq_req
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_flag <= 1'b0;
        end else if (irq_event) begin
            irq_flag <= 1'b1;
        end else if (ctrl1_wr) begin
            irq_flag <= 1'b0;
        end
    end

    assign irq_req = irq_flag && irq_en;
endmodule

// File: rtl/dcr_rd_mux.sv
module dcr_rd_mux
    import dcr_pkg::*;
#(
    parameter int unsigned RANGE_W  = 4,
    parameter int unsigned CHAN_W   = 3,
    parameter int unsigned ID_W     = 2,
    parameter logic [ID_W-1:0] BOARD_ID = '0
) (
    input  logic [ADDR_W-1:0]  addr,
    input  ptr_e               ptr_q,
    input  logic [RANGE_W-1:0] range_q,
    input  logic               conv_busy,
    input  logic [2:0]         din,
    input  logic               irq_flag,
    input  logic [CHAN_W-1:0]  cur_chan,
    input  logic [DATA_W-1:0]  conv_cfg,
    output logic [DATA_W-1:0]  rdata
);
    localparam int unsigned ID_PAD = DATA_W - ID_W;
    localparam logic [DATA_W-1:0] ID_BYTE = {{ID_PAD{1'b0}}, BOARD_ID};

    always_comb begin
        rdata = '0;
        case (addr)
            OFF_CTRL:  rdata = {conv_busy, din, irq_flag, cur_chan};
            OFF_SEL:   rdata = {2'b00, ptr_q, range_q};
            OFF_STAT2: rdata = (ptr_q == PTR_ID) ? ID_BYTE : conv_cfg;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/dcr_regbank.sv
module dcr_regbank
    import dcr_pkg::*;
#(
    parameter int unsigned ID_W     = 2,
    parameter logic [ID_W-1:0] BOARD_ID = 2'b10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] bus_addr,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       conv_busy,
    input  logic [2:0] din,
    input  logic [2:0] cur_chan,
    input  logic       irq_event,
    output logic [3:0] dout,
    output logic       irq_en,
    output logic [2:0] mux_chan,
    output logic [7:0] conv_cfg,
    output logic       conv_start,
    output logic       trig_rearm,
    output logic [2:0] scan_first,
    output logic [2:0] scan_last,
    output logic [3:0] range_code,
    output logic       irq_req
);
    localparam int unsigned CHAN_W  = 3;
    localparam int unsigned DOUT_W  = 4;
    localparam int unsigned RANGE_W = 4;

    ptr_e       ptr_q;
    logic [3:0] sel_oh;
    logic       sel_wr, ctrl_wr, ctrl1_wr, irq_flag;

    assign sel_wr  = bus_wr && (bus_addr == OFF_SEL);
    assign ctrl_wr = bus_wr && (bus_addr == OFF_CTRL);

    dcr_ptr_fsm #(.RANGE_W(RANGE_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_wr    (sel_wr),
        .ptr_we    (bus_wdata[7]),
        .ptr_val   (bus_wdata[5:4]),
        .range_val (bus_wdata[RANGE_W-1:0]),
        .ptr_q     (ptr_q),
        .sel_oh    (sel_oh),
        .range_q   (range_code)
    );

    dcr_ctrl_regs #(.CHAN_W(CHAN_W), .DOUT_W(DOUT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .sel_oh     (sel_oh),
        .wdata      (bus_wdata),
        .dout       (dout),
        .irq_en     (irq_en),
        .mux_chan   (mux_chan),
        .conv_cfg   (conv_cfg),
        .conv_start (conv_start),
        .trig_rearm (trig_rearm),
        .scan_first (scan_first),
        .scan_last  (scan_last),
        .ctrl1_wr   (ctrl1_wr)
    );

    dcr_irq u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_event (irq_event),
        .ctrl1_wr  (ctrl1_wr),
        .irq_en    (irq_en),
        .irq_flag  (irq_flag),
        .irq_req   (irq_req)
    );

    dcr_rd_mux #(
        .RANGE_W (RANGE_W),
        .CHAN_W  (CHAN_W),
        .ID_W    (ID_W),
        .BOARD_ID(BOARD_ID)
    ) u_rd (
        .addr      (bus_addr),
        .ptr_q     (ptr_q),
        .range_q   (range_code),
        .conv_busy (conv_busy),
        .din       (din),
        .irq_flag  (irq_flag),
        .cur_chan  (cur_chan),
        .conv_cfg  (conv_cfg),
        .rdata     (bus_rdata)
    );
endmodule

// File: rtl/dcr_regbank_chk.sv
module dcr_regbank_chk
    import dcr_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] bus_addr,
    input logic       bus_wr,
    input logic [7:0] bus_wdata,
    input logic       irq_event,
    input ptr_e       ptr_q,
    input logic       irq_flag,
    input logic       irq_en,
    input logic       irq_req,
    input logic [7:0] conv_cfg,
    input logic       conv_start,
    input logic [3:0] dout,
    input logic [2:0] scan_first,
    input logic [2:0] scan_last,
    input logic [3:0] range_code
);
    logic ctrl_wr, sel_wr;
    assign ctrl_wr = bus_wr && (bus_addr == OFF_CTRL);
    assign sel_wr  = bus_wr && (bus_addr == OFF_SEL);

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_wr && bus_wdata[7]) |=> $stable(ptr_q)); // R2
    AST_RANGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_wr && bus_wdata[7]) |=> $stable(range_code)); // R2
    AST_START_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> $past(ctrl_wr && ptr_q == PTR_CONV && bus_wdata[0])); // R4
    AST_CONV_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ptr_q == PTR_CONV && conv_cfg[0]) |=> $stable(conv_cfg[7:1])); // R5
    AST_ID_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ptr_q == PTR_ID) |=> ($stable(dout) && $stable(conv_cfg)
                                          && $stable(scan_first) && $stable(scan_last))); // R7
    AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        irq_event |=> irq_flag); // R8
    AST_IRQ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ptr_q == PTR_CTRL1 && !irq_event) |=> !irq_flag); // R8
    AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq_req); // R9
endmodule

bind dcr_regbank dcr_regbank_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .irq_event  (irq_event),
    .ptr_q      (ptr_q),
    .irq_flag   (irq_flag),
    .irq_en     (irq_en),
    .irq_req    (irq_req),
    .conv_cfg   (conv_cfg),
    .conv_start (conv_start),
    .dout       (dout),
    .scan_first (scan_first),
    .scan_last  (scan_last),
    .range_code (range_code)
);

// File: tb/dcr_regbank_tb.sv
`timescale 1ns/1ps
module dcr_regbank_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       conv_busy = 1'b0;
    logic [2:0] din = '0;
    logic [2:0] cur_chan = '0;
    logic       irq_event = 1'b0;
    logic [3:0] dout;
    logic       irq_en;
    logic [2:0] mux_chan;
    logic [7:0] conv_cfg;
    logic       conv_start, trig_rearm;
    logic [2:0] scan_first, scan_last;
    logic [3:0] range_code;
    logic       irq_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit probe = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    dcr_regbank u_dut (.*);

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read items and compares
    always @(negedge clk) begin
        #1;
        if (probe && exp_q.size() > 0) begin
            chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
    end

    task automatic rd(logic [2:0] a, logic [7:0] exp, string tag);
        @(negedge clk);
        bus_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        probe = 1'b1;
        @(negedge clk);
        probe = 1'b0;
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d, logic ev);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; irq_event = ev;
        @(negedge clk);
        bus_wr = 1'b0; irq_event = 1'b0;
    endtask

    initial begin
        #100000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 dout", {4'h0, dout}, 8'h00);
        chk("R1 conv_cfg", conv_cfg, 8'h00);
        chk("R1 misc", {irq_en, irq_req, conv_start, trig_rearm, 4'h0}, 8'h00);
        rd(3'd3, 8'h00, "R1 sel read");
        rd(3'd7, 8'h00, "R1 stat2 read");
        rd(3'd2, 8'h00, "R1 stat1 read");
        // R2 range vs pointer
        wr(3'd3, 8'h05, 1'b0);
        rd(3'd3, 8'h05, "R2 range only");
        wr(3'd3, 8'hA0, 1'b0);
        rd(3'd3, 8'h25, "R2 pointer only");
        // R3 control register 1
        wr(3'd3, 8'h80, 1'b0);
        wr(3'd2, 8'hB9, 1'b0);
        chk("R3 ctrl1", {dout, irq_en, mux_chan}, 8'hB9);
        chk("R4 ctrl1 leaves conv", conv_cfg, 8'h00);
        // R4 conversion config load
        wr(3'd3, 8'h90, 1'b0);
        bus_wdata = 8'hBE; bus_addr = 3'd2; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
        chk("R4 pulses no start", {6'h0, conv_start, trig_rearm}, 8'h01);
        chk("R4 cfg load", conv_cfg, 8'hBE);
        rd(3'd7, 8'hBE, "R11 mirror");
        wr(3'd2, 8'hC3, 1'b0);
        chk("R4 start pulse", {6'h0, conv_start, trig_rearm}, 8'h03);
        chk("R4 bit6 masked", conv_cfg, 8'h83);
        // R5 locked
        wr(3'd2, 8'h3D, 1'b0);
        chk("R5 locked cfg", conv_cfg, 8'h83);
        chk("R5 restart pulse", {6'h0, conv_start, trig_rearm}, 8'h03);
        wr(3'd2, 8'h7C, 1'b0);
        chk("R5 disable only", conv_cfg, 8'h82);
        // R6 scan limits
        wr(3'd3, 8'hA0, 1'b0);
        wr(3'd2, 8'h2B, 1'b0);
        chk("R6 scan", {2'b00, scan_last, scan_first}, 8'h2B);
        rd(3'd7, 8'h82, "R11 mirror ptr10");
        // R7 pointer 11
        wr(3'd3, 8'hB0, 1'b0);
        wr(3'd2, 8'hFF, 1'b0);
        chk("R7 dout", {dout, irq_en, mux_chan}, 8'hB9);
        chk("R7 cfg", conv_cfg, 8'h82);
        chk("R7 scan", {2'b00, scan_last, scan_first}, 8'h2B);
        rd(3'd7, 8'h02, "R11 id");
        rd(3'd3, 8'h35, "R2 readback ptr11");
        // R8/R9/R10 interrupt and status
        @(negedge clk); irq_event = 1'b1;
        @(negedge clk); irq_event = 1'b0;
        chk("R9 req set", {7'h0, irq_req}, 8'h01);
        conv_busy = 1'b1; din = 3'b101; cur_chan = 3'd6;
        rd(3'd2, 8'hDE, "R10 status");
        conv_busy = 1'b0; din = '0; cur_chan = '0;
        wr(3'd3, 8'h80, 1'b0);
        wr(3'd2, 8'h01, 1'b0);
        rd(3'd2, 8'h00, "R8 clear");
        chk("R9 req cleared", {7'h0, irq_req}, 8'h00);
        @(negedge clk); irq_event = 1'b1;
        @(negedge clk); irq_event = 1'b0;
        rd(3'd2, 8'h08, "R8 set");
        chk("R9 gated off", {7'h0, irq_req}, 8'h00);
        wr(3'd2, 8'h08, 1'b1);
        rd(3'd2, 8'h08, "R8 set wins");
        chk("R9 same cycle req", {7'h0, irq_req}, 8'h01);
        // R12 unused offsets
        rd(3'd0, 8'h00, "R12 off0");
        rd(3'd1, 8'h00, "R12 off1");
        rd(3'd4, 8'h00, "R12 off4");
        rd(3'd5, 8'h00, "R12 off5");
        rd(3'd6, 8'h00, "R12 off6");
        wr(3'd5, 8'hFF, 1'b0);
        wr(3'd0, 8'hFF, 1'b0);
        chk("R12 no write", {dout, irq_en, mux_chan}, 8'h08);
        rd(3'd3, 8'h05, "R12 sel untouched");
        repeat (2) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule